// File: doc/BRIEF.md
# Two-Wire Serial Memory Read Slave

This block is the slave side of a two-wire serial memory that only serves reads. It watches oversampled copies of the clock and data lines, recognises START, STOP and repeated START, and accepts a 7-bit device identifier followed by a read/write flag. A write-flagged transfer is treated as a dummy write. It carries two word-address bytes, most significant first, and these load an internal 14-bit address counter. No data is ever stored.

A read-flagged transfer streams bytes from the counter position. The position is either the address loaded just before a repeated START or whatever the counter held from earlier traffic. The master acknowledges each byte to ask for the next one and withholds the acknowledge to end the stream. The counter steps through every address bit and rolls over from the top of the array to zero.

The array is a synchronous read-only store whose contents are a fixed function of the address, so any reader can predict every byte. The block drives the data line only by pulling it low through an open-drain enable.

Top module: `twr_read_slave`

## Requirements
- R1: After reset and after any START or STOP the block releases the data line (sda_oe=0). Between a STOP and the next START it ignores all clock pulses and never pulls the line low.
- R2: A byte of {DEV_ID[6:0], rw} (rw is bit 0, sent last) that matches DEV_ID is acknowledged by holding SDA low during the ninth clock.
- R3: A device byte that does not match is not acknowledged. The block then leaves SDA released until the next START.
- R4: In a write-flagged transfer the next two bytes are the word address, high byte first, and each one is acknowledged. The counter becomes {high[5:0], low}, and the two top bits of the high byte are ignored.
- R5: After the address load, a repeated START with a matching read-flagged device byte is acknowledged and is followed by the byte stored at the loaded address.
- R6: A read-flagged transfer with no address bytes returns the byte at the current counter value. The counter is 0 after reset.
- R7: Each master acknowledge after a data byte makes the block send the byte at the next address (N, N+1, ...).
- R8: When the master does not acknowledge a data byte, the block releases SDA and sends nothing more until a new START.
- R9: The counter rolls over from 16383 to 0 and the stream continues.
- R10: The counter keeps its value across STOP, so a later current-address read continues at the last address sent plus one.
- R11: Data bytes are sent most significant bit first. The SDA enable changes only while SCL is low.
- R12: The byte stored at address a is ((a*29) mod 256) XOR (a div 256) XOR 0xA5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND level) |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest situation to reach from the ports is the counter rollover inside one sequential stream. Reaching it by streaming would take sixteen thousand bytes. The bench instead uses a dummy write whose high byte has its don't-care bits set, which places the counter two bytes below the top, and then acknowledges four bytes across the boundary. The same run also shows that the ignored high bits do not corrupt the address. The bench reaches the quiet states after a NACK and after a STOP by clocking whole bytes through them with the master releasing the line. Any pull-low by the slave would show up as a zero bit.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_ACK,
    S_TX,
    S_MACK,
    S_HOLD
  } twr_state_t;

  // Stored content as a pure function of the address (zero-extended to 16 bits).
  function automatic logic [7:0] pattern_byte(input logic [15:0] a);
    logic [15:0] prod;
    prod = a * 16'd29;
    return prod[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twr_pattern_store.sv
module twr_pattern_store
  import twr_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [15:0] addr_ext;
  assign addr_ext = 16'(rd_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= 8'h00;
    else        rd_data <= pattern_byte(addr_ext);
  end

endmodule

// File: rtl/twr_read_slave.sv
module twr_read_slave
  import twr_pkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'h50,
  parameter int         AW          = 14,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int         HI_BITS  = AW - 8;
  localparam logic [3:0] BYTE_LEN = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  twr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  twr_state_t           state, ret_state;
  logic [3:0]           bit_cnt;
  logic [7:0]           sh;
  logic [AW-1:0]        addr;
  logic [HI_BITS-1:0]   addr_hi;
  logic                 mack_ok;
  logic [7:0]           rd_data;

  twr_pattern_store #(.AW(AW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (addr),
    .rd_data (rd_data)
  );

  function automatic logic [AW-1:0] addr_inc(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [AW-1:0] compose_addr(input logic [HI_BITS-1:0] hi,
                                                 input logic [7:0] lo);
    return {hi, lo};
  endfunction

  // Named internal events, used by the state machine and by the checker.
  logic rx_state, rx_done, dev_match, addr_load, byte_load, ack_end, mack_end;

  assign rx_state  = (state == S_DEV) || (state == S_AHI) || (state == S_ALO);
  assign rx_done   = rx_state && scl_fall && (bit_cnt == BYTE_LEN);
  assign dev_match = (sh[7:1] == DEV_ID);
  assign addr_load = rx_done && (state == S_ALO);
  assign ack_end   = scl_fall && (state == S_ACK);
  assign mack_end  = scl_fall && (state == S_MACK);
  assign byte_load = !start_evt && !stop_evt &&
                     ((ack_end && ret_state == S_TX) || (mack_end && mack_ok));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      ret_state <= S_IDLE;
      bit_cnt   <= '0;
      sh        <= '0;
      addr      <= '0;
      addr_hi   <= '0;
      mack_ok   <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (start_evt) begin
      state   <= S_DEV;
      bit_cnt <= '0;
      sda_oe  <= 1'b0;
    end else if (stop_evt) begin
      state   <= S_IDLE;
      sda_oe  <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_AHI, S_ALO: begin
          if (scl_rise && bit_cnt < BYTE_LEN) begin
            sh      <= {sh[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (rx_done) begin
            bit_cnt <= '0;
            if (state == S_DEV) begin
              if (dev_match) begin
                sda_oe    <= 1'b1;
                state     <= S_ACK;
                ret_state <= sh[0] ? S_TX : S_AHI;
              end else begin
                state <= S_IDLE;
              end
            end else if (state == S_AHI) begin
              addr_hi   <= sh[HI_BITS-1:0];
              sda_oe    <= 1'b1;
              state     <= S_ACK;
              ret_state <= S_ALO;
            end else begin
              addr      <= compose_addr(addr_hi, sh);
              sda_oe    <= 1'b1;
              state     <= S_ACK;
              ret_state <= S_HOLD;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            state   <= ret_state;
            bit_cnt <= '0;
            if (ret_state == S_TX) begin
              sh     <= rd_data;
              sda_oe <= ~rd_data[7];
              addr   <= addr_inc(addr);
            end else begin
              sda_oe <= 1'b0;
            end
          end
        end
        S_TX: begin
          if (scl_rise) bit_cnt <= bit_cnt + 4'd1;
          if (scl_fall) begin
            if (bit_cnt == BYTE_LEN) begin
              sda_oe  <= 1'b0;
              state   <= S_MACK;
              bit_cnt <= '0;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) mack_ok <= ~sda_s;
          if (scl_fall) begin
            if (mack_ok) begin
              state   <= S_TX;
              bit_cnt <= '0;
              sh      <= rd_data;
              sda_oe  <= ~rd_data[7];
              addr    <= addr_inc(addr);
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/twr_read_checks.sv
module twr_read_checks
  import twr_pkg::*;
#(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_evt,
  input logic          stop_evt,
  input logic          byte_load,
  input logic          addr_load,
  input logic          sda_oe,
  input logic [AW-1:0] addr,
  input twr_state_t    state
);

  p_oe_moves_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(start_evt) && !$past(stop_evt) |-> !$past(scl_s));

  p_release_on_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> !sda_oe);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);

  p_step_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load |=> addr == AW'($past(addr) + 1'b1));

  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_load && (addr == '1) |=> addr == '0);

  p_addr_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_load && !addr_load |=> $stable(addr));

endmodule

bind twr_read_slave twr_read_checks #(.AW(AW)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_evt (start_evt),
  .stop_evt  (stop_evt),
  .byte_load (byte_load),
  .addr_load (addr_load),
  .sda_oe    (sda_oe),
  .addr      (addr),
  .state     (state)
);

// File: tb/twr_read_slave_test.sv
module twr_read_slave_test;

  localparam int         Q    = 8;
  localparam int         AW   = 14;
  localparam int         SPAN = 16384;
  localparam logic [6:0] DEV  = 7'h50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  twr_read_slave #(.DEV_ID(DEV), .AW(AW)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl),
    .sda_i  (sda_line),
    .sda_oe (sda_oe)
  );

  int checks = 0;
  int fails = 0;
  int model_addr = 0;
  int hi_oe_moves = 0;
  int scl_hi_run = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  // Reference content, written as plain integer arithmetic (R12).
  function automatic int ref_byte(int a);
    return ((a * 29) % 256) ^ (a / 256) ^ 165;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock monitor: the slave must not move its enable while SCL sits high (R11).
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_hi_run >= 4 && sda_oe != oe_prev) hi_oe_moves++;
      scl_hi_run = scl ? scl_hi_run + 1 : 0;
      oe_prev = sda_oe;
    end
  end

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(2*Q);
    sda_m = 1'b0; wq(2*Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1;   wq(2*Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(bit b);
    sda_m = b;  wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    b = sda_line; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic wr_byte(int v, output bit ack_low);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack_low = !b;
  endtask

  task automatic rd_byte(output int d, input bit more);
    bit b;
    d = 0;
    for (int i = 0; i < 8; i++) begin
      get_bit(b);
      d = (d << 1) | int'(b);
    end
    put_bit(!more);
  endtask

  task automatic dummy_write(int hi, int lo);
    bit ak;
    bus_start();
    wr_byte({DEV, 1'b0}, ak); chk("R2 device write ack", int'(ak), 1);
    wr_byte(hi, ak);          chk("R4 high address ack", int'(ak), 1);
    wr_byte(lo, ak);          chk("R4 low address ack", int'(ak), 1);
    model_addr = ((hi % 64) * 256 + lo) % SPAN;
  endtask

  task automatic read_stream(int count, string tag);
    bit ak;
    int d;
    bus_start();
    wr_byte({DEV, 1'b1}, ak); chk("R5 device read ack", int'(ak), 1);
    for (int k = 0; k < count; k++) begin
      rd_byte(d, k < count - 1);
      chk(tag, d, ref_byte(model_addr));
      model_addr = (model_addr + 1) % SPAN;
    end
    wq(2);
    chk("R8 released after NACK", int'(sda_oe), 0);
  endtask

  initial begin
    bit ak;
    int d;
    wq(5);
    chk("R1 reset release", int'(sda_oe), 0);
    rst_n = 1'b1;
    scl = 1'b0;
    wq(4);

    // Current-address read straight after reset starts at 0 (R6).
    read_stream(1, "R6 current read from reset");
    bus_stop();

    // Selective read at 0x1234 (R4, R5).
    dummy_write(8'h12, 8'h34);
    read_stream(1, "R5 selective read byte");
    bus_stop();

    // Counter kept across STOP (R10).
    read_stream(1, "R10 read after STOP continues");
    bus_stop();

    // Sequential stream of five bytes (R7, R11 bit order).
    dummy_write(8'h01, 8'h00);
    read_stream(5, "R7 sequential byte");
    bus_stop();

    // Don't-care high bits and rollover (R4, R9).
    dummy_write(8'hFF, 8'hFE);
    chk("R4 top bits ignored", model_addr, 16382);
    read_stream(4, "R9 rollover stream");
    bus_stop();
    chk("R9 model wrapped", model_addr, 2);

    // No further data after NACK without STOP (R8).
    read_stream(1, "R8 single byte");
    rd_byte(d, 1'b0);
    chk("R8 quiet after NACK", d, 8'hFF);
    bus_stop();

    // Mismatching device byte (R3).
    bus_start();
    wr_byte({7'h51, 1'b1}, ak);
    chk("R3 mismatch not acked", int'(ak), 0);
    rd_byte(d, 1'b0);
    chk("R3 line released after mismatch", d, 8'hFF);
    bus_stop();
    bus_start();
    wr_byte({7'h28, 1'b0}, ak);
    chk("R3 mismatch write not acked", int'(ak), 0);
    bus_stop();

    // Clock pulses after STOP with no START are ignored (R1).
    wr_byte({DEV, 1'b1}, ak);
    chk("R1 no ack without START", int'(ak), 0);
    rd_byte(d, 1'b0);
    chk("R1 no data without START", d, 8'hFF);

    // Counter untouched by the mismatch and idle traffic (R10).
    read_stream(2, "R10 counter after idle traffic");
    bus_stop();

    chk("R11 enable moves while SCL high", hi_oe_moves, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule